// File: doc/BRIEF.md
# Shadow Memory Region Attribute Decoder

This block decides, for each memory address in the top 256 KB of a 1 MB address space, whether a read and whether a write should be served by internal DRAM (a "shadowed" copy) or passed to the external bus. The lower 128 KB of that window holds expansion ROM images and is cut into eight 16 KB segments. The upper 128 KB holds the system firmware and is cut into four 32 KB segments. Each segment has its own enable bit. One read-routing bit and one write-routing bit apply to every enabled segment in both halves.

Two 8-bit control registers hold the settings. The segment-enable register covers the expansion ROM half. The routing register holds the four firmware-segment enables and the read and write routing bits. Both registers reset to zero, so every access goes external after reset. The attribute outputs are combinational in the address and registered in the control state. A one-cycle change pulse follows every register write, so that downstream logic can drop any cached translations. Addresses below the window are flagged as out of range.

Top module: `shadow_attr_dec`

## Requirements
- R1: After reset both control registers read 0x00, both internal flags are 0 for every address, and the change pulse is 0.
- R2: A write strobe on the segment-enable register stores all 8 data bits on that clock edge. With no strobe, the register holds its value.
- R3: For an address in 0xC0000–0xDFFFF, the segment index is address bits [16:14], and bit i of the segment-enable register enables segment i. The read-internal flag is 1 exactly when the segment is enabled and bit 4 of the routing register is 1.
- R4: For any address in 0xC0000–0xFFFFF in an enabled segment, the write-internal flag equals bit 5 of the routing register.
- R5: For an address in 0xE0000–0xFFFFF, the segment index is address bits [16:15], and routing register bits 0–3 enable segments 0–3. Read routing follows bit 4, as in R3.
- R6: Bit 6 of the routing register cannot be written and always reads 0. The other seven bits store the written data.
- R7: For an address below 0xC0000, the out-of-range flag is 1 and both internal flags are 0. Inside the window the out-of-range flag is 0.
- R8: The change pulse is 1 for exactly the one cycle after a clock edge on which either register was written, even when the written value is unchanged. Otherwise it is 0.
- R9: A disabled segment routes both reads and writes externally (both flags 0), whatever bits 4 and 5 hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_we | input | 1 | Write strobe for the segment-enable register |
| seg_wdata | input | 8 | Data for the segment-enable register |
| route_we | input | 1 | Write strobe for the routing register |
| route_wdata | input | 8 | Data for the routing register |
| mem_addr | input | 20 | Address being classified |
| seg_q | output | 8 | Segment-enable register contents |
| route_q | output | 8 | Routing register contents (bit 6 forced to 0) |
| rd_internal | output | 1 | 1: the read goes to internal DRAM |
| wr_internal | output | 1 | 1: the write goes to internal DRAM |
| out_of_window | output | 1 | 1: the address lies below 0xC0000 |
| cfg_changed | output | 1 | One-cycle pulse after any register write |

## Verification
Several properties are checked on every cycle: the flags stay clear outside the window, neither internal flag is raised without its routing bit, the reserved bit stays at zero, the change pulse follows the write strobes one cycle later, and the registers hold their values between writes. The mapping from address to segment index, which segment bit gates which address, and the difference in granularity between the two halves are shown only by the bench. The bench compares each address against a reference model, for random and directed register values and for addresses at segment edges.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

   // Positions inside the routing register
   localparam int RD_ROUTE_BIT = 4;
   localparam int WR_ROUTE_BIT = 5;
   localparam int LOCKED_BIT   = 6;

   // Window codes on the top three address bits
   localparam logic [2:0] ROM_AREA_CODE = 3'b110;
   localparam logic [2:0] FW_AREA_CODE  = 3'b111;

   typedef struct packed {
      logic rd_int;
      logic wr_int;
      logic oow;
   } shadow_attr_t;

endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs #(
   parameter int DATA_W     = 8,
   parameter int LOCKED_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seg_we,
   input  logic [DATA_W-1:0] seg_wdata,
   input  logic              route_we,
   input  logic [DATA_W-1:0] route_wdata,
   output logic [DATA_W-1:0] seg_q,
   output logic [DATA_W-1:0] route_q,
   output logic              changed
);
   localparam logic [DATA_W-1:0] ROUTE_MASK = ~(DATA_W'(1) << LOCKED_BIT);

   generate
      if (LOCKED_BIT >= DATA_W) begin : g_bad_locked
         $error("shadow_cfg_regs: LOCKED_BIT outside the register");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg_q   <= '0;
         route_q <= '0;
         changed <= 1'b0;
      end else begin
         if (seg_we)   seg_q   <= seg_wdata;
         if (route_we) route_q <= route_wdata & ROUTE_MASK;
         changed <= seg_we | route_we;
      end
   end
endmodule

// File: rtl/shadow_area_dec.sv
module shadow_area_dec #(
   parameter int         ADDR_W    = 20,
   parameter int         SEGS      = 8,
   parameter logic [2:0] AREA_CODE = 3'b110
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SEGS-1:0]   en_mask,
   output logic              hit,
   output logic              seg_en
);
   localparam int WIN_LSB = ADDR_W - 3;
   localparam int IDX_W   = (SEGS > 1) ? $clog2(SEGS) : 1;
   localparam int IDX_LSB = WIN_LSB - $clog2(SEGS);

   generate
      if ((SEGS & (SEGS - 1)) != 0 || SEGS < 1) begin : g_bad_segs
         $error("shadow_area_dec: SEGS must be a power of two");
      end
      if (IDX_LSB < 0) begin : g_bad_width
         $error("shadow_area_dec: too many segments for the address width");
      end
   endgenerate

   assign hit = (addr[ADDR_W-1:WIN_LSB] == AREA_CODE);

   generate
      if (SEGS == 1) begin : g_single
         assign seg_en = en_mask[0];
         logic unused_addr;
         assign unused_addr = ^addr[WIN_LSB-1:0];
      end else begin : g_multi
         logic [IDX_W-1:0] idx;
         assign idx    = addr[WIN_LSB-1:IDX_LSB];
         assign seg_en = en_mask[idx];
         if (IDX_LSB > 0) begin : g_low_bits
            logic unused_addr;
            assign unused_addr = ^addr[IDX_LSB-1:0];
         end
      end
   endgenerate
endmodule

// File: rtl/shadow_attr_gen.sv
module shadow_attr_gen
   import shadow_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              rom_hit,
   input  logic              rom_en,
   input  logic              fw_hit,
   input  logic              fw_en,
   input  logic              below,
   input  logic [DATA_W-1:0] route,
   output shadow_attr_t      attr
);
   generate
      if (WR_ROUTE_BIT >= DATA_W || RD_ROUTE_BIT >= DATA_W) begin : g_bad_bits
         $error("shadow_attr_gen: routing bits outside the register");
      end
   endgenerate

   logic seg_on;

   always_comb begin
      seg_on      = (rom_hit & rom_en) | (fw_hit & fw_en);
      attr.rd_int = seg_on & route[RD_ROUTE_BIT];
      attr.wr_int = seg_on & route[WR_ROUTE_BIT];
      attr.oow    = below;
   end
endmodule

// File: rtl/shadow_attr_dec.sv
module shadow_attr_dec
   import shadow_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int DATA_W  = 8,
   parameter int ROM_SEGS = 8,
   parameter int FW_SEGS  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seg_we,
   input  logic [DATA_W-1:0] seg_wdata,
   input  logic              route_we,
   input  logic [DATA_W-1:0] route_wdata,
   input  logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] seg_q,
   output logic [DATA_W-1:0] route_q,
   output logic              rd_internal,
   output logic              wr_internal,
   output logic              out_of_window,
   output logic              cfg_changed
);
   generate
      if (ROM_SEGS > DATA_W) begin : g_bad_rom
         $error("shadow_attr_dec: ROM_SEGS exceeds register width");
      end
      if (FW_SEGS > RD_ROUTE_BIT) begin : g_bad_fw
         $error("shadow_attr_dec: FW_SEGS overlaps the routing bits");
      end
   endgenerate

   logic         rom_hit, rom_en, fw_hit, fw_en, below;
   shadow_attr_t attr;

   shadow_cfg_regs #(.DATA_W(DATA_W), .LOCKED_BIT(LOCKED_BIT)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .seg_we(seg_we), .seg_wdata(seg_wdata),
      .route_we(route_we), .route_wdata(route_wdata),
      .seg_q(seg_q), .route_q(route_q), .changed(cfg_changed)
   );

   shadow_area_dec #(.ADDR_W(ADDR_W), .SEGS(ROM_SEGS), .AREA_CODE(ROM_AREA_CODE)) u_rom (
      .addr(mem_addr), .en_mask(seg_q[ROM_SEGS-1:0]), .hit(rom_hit), .seg_en(rom_en)
   );

   shadow_area_dec #(.ADDR_W(ADDR_W), .SEGS(FW_SEGS), .AREA_CODE(FW_AREA_CODE)) u_fw (
      .addr(mem_addr), .en_mask(route_q[FW_SEGS-1:0]), .hit(fw_hit), .seg_en(fw_en)
   );

   assign below = (mem_addr[ADDR_W-1:ADDR_W-3] < ROM_AREA_CODE);

   shadow_attr_gen #(.DATA_W(DATA_W)) u_gen (
      .rom_hit(rom_hit), .rom_en(rom_en), .fw_hit(fw_hit), .fw_en(fw_en),
      .below(below), .route(route_q), .attr(attr)
   );

   assign rd_internal   = attr.rd_int;
   assign wr_internal   = attr.wr_int;
   assign out_of_window = attr.oow;
endmodule

// File: rtl/shadow_attr_dec_chk.sv
module shadow_attr_dec_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              seg_we,
   input logic              route_we,
   input logic [DATA_W-1:0] seg_q,
   input logic [DATA_W-1:0] route_q,
   input logic              rd_internal,
   input logic              wr_internal,
   input logic              out_of_window,
   input logic              cfg_changed
);
   // R7: nothing internal below the window
   p_oow_external_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_of_window |-> (!rd_internal && !wr_internal));

   // R3: read routed internally only with the read routing bit set
   p_rd_needs_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_internal |-> route_q[4]);

   // R4: write routed internally only with the write routing bit set
   p_wr_needs_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_internal |-> route_q[5]);

   // R6: locked bit stays clear
   p_locked_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      route_q[6] == 1'b0);

   // R8: pulse follows a write
   p_pulse_after_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_we || route_we) |=> cfg_changed);

   // R8: no pulse without a write
   p_no_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(seg_we || route_we) |=> !cfg_changed);

   // R2: register holds without a strobe
   p_seg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !seg_we |=> $stable(seg_q));
endmodule

bind shadow_attr_dec shadow_attr_dec_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .route_we(route_we),
   .seg_q(seg_q), .route_q(route_q), .rd_internal(rd_internal),
   .wr_internal(wr_internal), .out_of_window(out_of_window),
   .cfg_changed(cfg_changed)
);

// File: tb/shadow_attr_dec_tb_top.sv
`timescale 1ns/100ps
module shadow_attr_dec_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        seg_we = 1'b0, route_we = 1'b0;
   logic [7:0]  seg_wdata = '0, route_wdata = '0;
   logic [19:0] mem_addr = '0;
   logic [7:0]  seg_q, route_q;
   logic        rd_internal, wr_internal, out_of_window, cfg_changed;

   int n_chk = 0, n_bad = 0;
   int cycles = 0;
   bit done = 1'b0;

   logic [7:0] m_seg = '0, m_route = '0;
   logic       m_pulse = 1'b0;

   always #2.5 clk = ~clk;

   shadow_attr_dec dut_i (
      .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_wdata(seg_wdata),
      .route_we(route_we), .route_wdata(route_wdata), .mem_addr(mem_addr),
      .seg_q(seg_q), .route_q(route_q), .rd_internal(rd_internal),
      .wr_internal(wr_internal), .out_of_window(out_of_window),
      .cfg_changed(cfg_changed)
   );

   // Reference: is the segment holding a enabled?
   function automatic logic seg_on(input logic [19:0] a, input logic [7:0] s, input logic [7:0] r);
      if (a[19:17] == 3'b110) return s[a[16:14]];
      if (a[19:17] == 3'b111) return r[a[16:15]];
      return 1'b0;
   endfunction
   function automatic logic exp_rd(input logic [19:0] a, input logic [7:0] s, input logic [7:0] r);
      return seg_on(a, s, r) & r[4];
   endfunction
   function automatic logic exp_wr(input logic [19:0] a, input logic [7:0] s, input logic [7:0] r);
      return seg_on(a, s, r) & r[5];
   endfunction

   task automatic cmp(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s addr=%05h act=%02h exp=%02h", req, mem_addr, act, exp);
      end
   endtask

   task automatic check_all();
      string rq;
      rq = (mem_addr[19:17] == 3'b111) ? "R5" : "R3";
      if (!seg_on(mem_addr, m_seg, m_route) && mem_addr[19:17] >= 3'b110) rq = "R9";
      cmp("R2 seg_q", seg_q, m_seg);
      cmp("R6 route_q", route_q, m_route);
      cmp({rq, " rd"}, {7'd0, rd_internal}, {7'd0, exp_rd(mem_addr, m_seg, m_route)});
      cmp("R4 wr", {7'd0, wr_internal}, {7'd0, exp_wr(mem_addr, m_seg, m_route)});
      cmp("R7 oow", {7'd0, out_of_window}, {7'd0, (mem_addr[19:17] < 3'b110)});
      cmp("R8 pulse", {7'd0, cfg_changed}, {7'd0, m_pulse});
   endtask

   // One cycle: drive at negedge, clock edge, check at next negedge
   task automatic step(input logic sw, input logic [7:0] sd,
                       input logic rw, input logic [7:0] rd, input logic [19:0] a);
      seg_we = sw; seg_wdata = sd; route_we = rw; route_wdata = rd; mem_addr = a;
      @(posedge clk);
      if (sw) m_seg = sd;
      if (rw) m_route = rd & 8'hBF;
      m_pulse = sw | rw;
      @(negedge clk);
      check_all();
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog act=%0d exp<=100000", cycles);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state, probe both halves
      mem_addr = 20'hC0000; check_all();
      cmp("R1 seg reset", seg_q, 8'h00);
      cmp("R1 route reset", route_q, 8'h00);
      mem_addr = 20'hF0000; check_all();

      // R6: write all ones, bit 6 must read 0
      step(1'b0, 8'h00, 1'b1, 8'hFF, 20'hE0000);
      cmp("R6 locked bit", route_q, 8'hBF);
      // R9: segments disabled with routing bits set
      step(1'b0, 8'h00, 1'b1, 8'h30, 20'hC4000);
      step(1'b0, 8'h00, 1'b0, 8'h00, 20'hF8000);
      // R3: single ROM segment 3 at edges
      step(1'b1, 8'h08, 1'b0, 8'h00, 20'hCC000);
      step(1'b0, 8'h00, 1'b0, 8'h00, 20'hCFFFF);
      step(1'b0, 8'h00, 1'b0, 8'h00, 20'hD0000);
      step(1'b0, 8'h00, 1'b0, 8'h00, 20'hCBFFF);
      // R5: firmware segment 2, read only
      step(1'b0, 8'h00, 1'b1, 8'h14, 20'hF0000);
      step(1'b0, 8'h00, 1'b0, 8'h00, 20'hF7FFF);
      step(1'b0, 8'h00, 1'b0, 8'h00, 20'hEFFFF);
      // R7: just below the window
      step(1'b0, 8'h00, 1'b0, 8'h00, 20'hBFFFF);
      // R8: rewrite same value still pulses
      step(1'b1, 8'h08, 1'b1, 8'h14, 20'hCC000);
      step(1'b0, 8'h00, 1'b0, 8'h00, 20'hCC000);

      for (int i = 0; i < 3000; i++) begin
         logic [19:0] a;
         a = 20'($urandom);
         if ($urandom % 4 != 0) a[19:18] = 2'b11;
         step(($urandom % 5) == 0, 8'($urandom), ($urandom % 5) == 0, 8'($urandom), a);
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule